// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Recency Stamps

This block caches virtual-to-physical page translations in a small, fully associative array. Each slot holds a page-aligned virtual base, a physical frame base, the page size as log2 of its byte count, and four attribute bits: global, user-accessible, writable and uncacheable. Slots can have different page sizes. A lookup compares only the address bits above the slot's own page offset. The physical address is the frame with the offset bits of the virtual address ORed in.

The requester drives one operation per cycle with `req_valid` and `req_op`. The operations are lookup, insert, flush of every slot, flush of only the non-global slots, and invalidate of one page. A lookup hit also runs the paging permission checks: user against supervisor, write protection, and a store probe that tests writability without writing. Every response is registered and appears exactly one cycle after the request.

Replacement uses one free-running sequence counter. A slot is stamped with the counter value when it is filled. A lookup that asks for a recency update also stamps the slot. When no slot is free, the slot with the smallest stamp is evicted.

Top module: `tlbfa`

## Requirements
- R1: After reset no slot is valid, `rsp_valid` is low, and the first lookup of any address misses.
- R2: Each request with `req_valid` high yields `rsp_valid` high exactly one cycle later, and a cycle without a request yields `rsp_valid` low. The `req_op` codes are 0 lookup, 1 insert, 2 flush all, 3 flush non-global, 4 invalidate page.
- R3: A lookup hits a valid slot when the address bits at and above that slot's page-size log2 equal the slot's base. `rsp_pa` is then the frame ORed with the address bits below that position, and `rsp_nc` copies the slot's uncacheable bit. If several slots match, the lowest index wins. A miss returns `rsp_hit`, `rsp_slot` and `rsp_pa` all zero.
- R4: An insert whose page-aligned address already matches a valid slot changes no slot. It responds with `rsp_hit` high and that slot's index.
- R5: An insert that matches no slot fills the lowest-index invalid slot and reports it in `rsp_slot` with `rsp_hit` low. The stored base is the address with its offset bits cleared.
- R6: When every slot is valid, an insert replaces the slot with the smallest stamp. A fill always takes a new stamp from an increasing counter. A lookup hit takes one only when `req_upd_lru` is high.
- R7: Flush all leaves every slot invalid.
- R8: Flush non-global invalidates only the valid slots whose global bit is clear.
- R9: Invalidate page clears the lowest-index slot matching `req_va`, if there is one, and reports the match in `rsp_hit`.
- R10: An access is in user mode when `req_cpl` is 3 and `req_force_sup` is low. A user-mode access to a page without the user bit faults, with `rsp_fault_wr` equal to `req_write`.
- R11: A write is bad when the page is not writable and the access is in user mode or `wp_en` is high. A bad write access faults with `rsp_fault_wr` high.
- R12: A store probe that would be a bad write faults with `rsp_fault_wr` high. A probe or write on a writable page, and any miss, does not fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_va | input | VA_W | Virtual address for lookup, insert or invalidate |
| req_upd_lru | input | 1 | Refresh recency stamp on lookup hit |
| req_write | input | 1 | Lookup is a write access |
| req_probe | input | 1 | Lookup is a store probe |
| req_cpl | input | 2 | Current privilege level |
| req_force_sup | input | 1 | Treat access as supervisor |
| wp_en | input | 1 | Write protection applies to supervisor |
| ins_frame | input | PA_W | Physical frame base for insert |
| ins_log | input | LOG_W | log2 of page bytes for insert |
| ins_glob | input | 1 | Insert global bit |
| ins_user | input | 1 | Insert user bit |
| ins_wr | input | 1 | Insert writable bit |
| ins_nc | input | 1 | Insert uncacheable bit |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Matching slot found |
| rsp_slot | output | IDX_W | Slot index used or matched |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_nc | output | 1 | Uncacheable attribute |
| rsp_fault | output | 1 | Permission fault |
| rsp_fault_wr | output | 1 | Fault reported as a write |

## Verification
The bench targets the victim choice after a lookup with the recency update and a lookup without it. A design that stamps on every lookup, or never stamps on lookup, evicts the wrong slot. It inserts a duplicate page to catch a design that allocates a second copy, and uses a large page to catch a design that masks with a fixed offset width and drops the middle address bits. It runs the store probe, the supervisor write under write protection and the forced-supervisor access at user level, where a mis-ordered permission check reports the wrong fault or the wrong write flag. It also runs a flush that must keep the global slots, where a design that ignores the global bit loses them.

// File: rtl/tlbfa_pkg.sv
package tlbfa_pkg;

  typedef enum logic [2:0] {
    OP_LOOKUP      = 3'd0,
    OP_INSERT      = 3'd1,
    OP_FLUSH_ALL   = 3'd2,
    OP_FLUSH_LOCAL = 3'd3,
    OP_INVAL       = 3'd4
  } tlb_op_e;

  typedef struct packed {
    logic glob;
    logic usr;
    logic wr;
    logic nc;
  } page_attr_t;

  // low-order ones covering a page offset of 2**lg bytes (64-bit wide, callers truncate)
  function automatic logic [63:0] offset_ones(input logic [6:0] lg);
    return ~({64{1'b1}} << lg);
  endfunction

endpackage

// File: rtl/tlbfa_match.sv
module tlbfa_match #(
  parameter int VA_W  = 32,
  parameter int LOG_W = 6
) (
  input  logic             ent_valid,
  input  logic [VA_W-1:0]  ent_base,
  input  logic [LOG_W-1:0] ent_log,
  input  logic [VA_W-1:0]  q_va,
  output logic             hit
);
  import tlbfa_pkg::*;

  logic [VA_W-1:0] keep_bits;
  assign keep_bits = ~VA_W'(offset_ones(7'(ent_log)));
  assign hit = ent_valid && (((ent_base ^ q_va) & keep_bits) == '0);
endmodule

// File: rtl/tlbfa_pick.sv
module tlbfa_pick #(
  parameter int N       = 8,
  parameter int STAMP_W = 32,
  parameter int IDX_W   = 3
) (
  input  logic [N-1:0]              valid,
  input  logic [N-1:0]              hit_vec,
  input  logic [N-1:0][STAMP_W-1:0] stamps,
  output logic                      hit_any,
  output logic [IDX_W-1:0]          hit_idx,
  output logic                      free_any,
  output logic [IDX_W-1:0]          victim_idx
);
  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   old_idx;
  logic [STAMP_W-1:0] old_stamp;

  always_comb begin
    hit_any   = 1'b0;
    hit_idx   = '0;
    free_any  = 1'b0;
    free_idx  = '0;
    old_idx   = '0;
    old_stamp = stamps[0];
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!valid[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    for (int i = 1; i < N; i++) begin
      if (stamps[i] < old_stamp) begin
        old_stamp = stamps[i];
        old_idx   = IDX_W'(i);
      end
    end
    victim_idx = free_any ? free_idx : old_idx;
  end
endmodule

// File: rtl/tlbfa_perm.sv
module tlbfa_perm (
  input  logic       hit,
  input  logic       pg_user,
  input  logic       pg_wr,
  input  logic [1:0] cpl,
  input  logic       force_sup,
  input  logic       wp,
  input  logic       is_write,
  input  logic       probe,
  output logic       fault,
  output logic       fault_wr
);
  logic user_mode, bad_wr, priv_fault, wr_fault, probe_fault;

  assign user_mode   = (cpl == 2'd3) && !force_sup;
  assign bad_wr      = !pg_wr && (user_mode || wp);
  assign priv_fault  = user_mode && !pg_user;
  assign wr_fault    = is_write && bad_wr;
  assign probe_fault = probe && bad_wr;

  assign fault    = hit && (priv_fault || wr_fault || probe_fault);
  assign fault_wr = hit && (is_write ? (priv_fault || wr_fault) : (!priv_fault && probe_fault));
endmodule

// File: rtl/tlbfa.sv
module tlbfa #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int LOG_W   = 6,
  parameter int STAMP_W = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_upd_lru,
  input  logic             req_write,
  input  logic             req_probe,
  input  logic [1:0]       req_cpl,
  input  logic             req_force_sup,
  input  logic             wp_en,
  input  logic [PA_W-1:0]  ins_frame,
  input  logic [LOG_W-1:0] ins_log,
  input  logic             ins_glob,
  input  logic             ins_user,
  input  logic             ins_wr,
  input  logic             ins_nc,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_slot,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_nc,
  output logic             rsp_fault,
  output logic             rsp_fault_wr
);
  import tlbfa_pkg::*;

  logic [ENTRIES-1:0]              valid_q;
  logic [ENTRIES-1:0][VA_W-1:0]    base_q;
  logic [ENTRIES-1:0][PA_W-1:0]    frame_q;
  logic [ENTRIES-1:0][LOG_W-1:0]   log_q;
  page_attr_t [ENTRIES-1:0]        attr_q;
  logic [ENTRIES-1:0][STAMP_W-1:0] stamp_q;
  logic [STAMP_W-1:0]              seq_q;

  // named events
  logic lk_fire, ins_fire, fa_fire, fl_fire, inv_fire;
  logic alloc_we, touch_we;
  logic hit_any, free_any;
  logic [IDX_W-1:0] hit_idx, victim_idx;
  logic [ENTRIES-1:0] hit_vec, glob_vec, fill_sel, touch_sel, drop_sel;
  logic [VA_W-1:0] ins_base, q_va;
  logic [PA_W-1:0] pa_c;
  logic fault_c, fault_wr_c;

  assign lk_fire  = req_valid && (req_op == OP_LOOKUP);
  assign ins_fire = req_valid && (req_op == OP_INSERT);
  assign fa_fire  = req_valid && (req_op == OP_FLUSH_ALL);
  assign fl_fire  = req_valid && (req_op == OP_FLUSH_LOCAL);
  assign inv_fire = req_valid && (req_op == OP_INVAL);

  assign ins_base = req_va & ~VA_W'(offset_ones(7'(ins_log)));
  assign q_va     = ins_fire ? ins_base : req_va;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_slot
      tlbfa_match #(.VA_W(VA_W), .LOG_W(LOG_W)) u_match (
        .ent_valid (valid_q[g]),
        .ent_base  (base_q[g]),
        .ent_log   (log_q[g]),
        .q_va      (q_va),
        .hit       (hit_vec[g])
      );
      assign glob_vec[g] = attr_q[g].glob;
    end
  endgenerate

  tlbfa_pick #(.N(ENTRIES), .STAMP_W(STAMP_W), .IDX_W(IDX_W)) u_pick (
    .valid      (valid_q),
    .hit_vec    (hit_vec),
    .stamps     (stamp_q),
    .hit_any    (hit_any),
    .hit_idx    (hit_idx),
    .free_any   (free_any),
    .victim_idx (victim_idx)
  );

  assign alloc_we  = ins_fire && !hit_any;
  assign touch_we  = lk_fire && hit_any && req_upd_lru;
  assign fill_sel  = alloc_we ? (ENTRIES'(1) << victim_idx) : '0;
  assign touch_sel = touch_we ? (ENTRIES'(1) << hit_idx) : '0;
  assign drop_sel  = fa_fire ? valid_q :
                     fl_fire ? (valid_q & ~glob_vec) :
                     (inv_fire && hit_any) ? (ENTRIES'(1) << hit_idx) : '0;

  assign pa_c = frame_q[hit_idx] | PA_W'(req_va & VA_W'(offset_ones(7'(log_q[hit_idx]))));

  tlbfa_perm u_perm (
    .hit       (lk_fire && hit_any),
    .pg_user   (attr_q[hit_idx].usr),
    .pg_wr     (attr_q[hit_idx].wr),
    .cpl       (req_cpl),
    .force_sup (req_force_sup),
    .wp        (wp_en),
    .is_write  (req_write),
    .probe     (req_probe),
    .fault     (fault_c),
    .fault_wr  (fault_wr_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      base_q  <= '0;
      frame_q <= '0;
      log_q   <= '0;
      attr_q  <= '0;
      stamp_q <= '0;
      seq_q   <= '0;
    end else begin
      if (alloc_we || touch_we) seq_q <= seq_q + 1'b1;
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_sel[i]) begin
          valid_q[i] <= 1'b1;
          base_q[i]  <= ins_base;
          frame_q[i] <= ins_frame;
          log_q[i]   <= ins_log;
          attr_q[i]  <= '{glob: ins_glob, usr: ins_user, wr: ins_wr, nc: ins_nc};
          stamp_q[i] <= seq_q;
        end else if (touch_sel[i]) begin
          stamp_q[i] <= seq_q;
        end
        if (drop_sel[i]) valid_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_slot     <= '0;
      rsp_pa       <= '0;
      rsp_nc       <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_fault_wr <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_hit      <= (lk_fire || ins_fire || inv_fire) && hit_any;
      rsp_slot     <= alloc_we ? victim_idx :
                      ((lk_fire || ins_fire || inv_fire) && hit_any) ? hit_idx : '0;
      rsp_pa       <= (lk_fire && hit_any) ? pa_c : '0;
      rsp_nc       <= lk_fire && hit_any && attr_q[hit_idx].nc;
      rsp_fault    <= fault_c;
      rsp_fault_wr <= fault_wr_c;
    end
  end
endmodule

// File: rtl/tlbfa_chk.sv
module tlbfa_chk #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_fault,
  input logic               rsp_fault_wr,
  input logic               ins_fire,
  input logic               fa_fire,
  input logic               hit_any,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] fill_sel
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R12
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit);
  // R11
  fault_wr_implies_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault_wr |-> rsp_fault);
  // R5
  single_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_sel));
  // R4
  dup_insert_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && hit_any) |=> $stable(valid_q));
  // R5
  free_fill_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && !hit_any && !(&valid_q)) |=>
      ($countones(valid_q) == $countones($past(valid_q)) + 1));
  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fa_fire |=> (valid_q == '0));
endmodule

bind tlbfa tlbfa_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_fault    (rsp_fault),
  .rsp_fault_wr (rsp_fault_wr),
  .ins_fire     (ins_fire),
  .fa_fire      (fa_fire),
  .hit_any      (hit_any),
  .valid_q      (valid_q),
  .fill_sel     (fill_sel)
);

// File: tb/tlbfa_tb.sv
module tlbfa_tb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [31:0] req_va = '0;
  logic        req_upd_lru = 1'b0, req_write = 1'b0, req_probe = 1'b0;
  logic [1:0]  req_cpl = '0;
  logic        req_force_sup = 1'b0, wp_en = 1'b0;
  logic [31:0] ins_frame = '0;
  logic [5:0]  ins_log = '0;
  logic        ins_glob = 1'b0, ins_user = 1'b0, ins_wr = 1'b0, ins_nc = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_nc, rsp_fault, rsp_fault_wr;
  logic [2:0]  rsp_slot;
  logic [31:0] rsp_pa;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  tlbfa #(.ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_va(req_va),
    .req_upd_lru(req_upd_lru), .req_write(req_write), .req_probe(req_probe),
    .req_cpl(req_cpl), .req_force_sup(req_force_sup), .wp_en(wp_en),
    .ins_frame(ins_frame), .ins_log(ins_log), .ins_glob(ins_glob), .ins_user(ins_user),
    .ins_wr(ins_wr), .ins_nc(ins_nc), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_slot(rsp_slot), .rsp_pa(rsp_pa), .rsp_nc(rsp_nc), .rsp_fault(rsp_fault),
    .rsp_fault_wr(rsp_fault_wr)
  );

  // reference model
  bit          mv[N];
  logic [31:0] mbase[N], mfr[N];
  int          mlg[N];
  bit          mg[N], mu[N], mw[N], mc[N];
  longint      mst[N];
  longint      mseq = 0;

  function automatic logic [31:0] low_mask(input int lg);
    return (lg >= 32) ? 32'hFFFF_FFFF : ((32'h1 << lg) - 32'h1);
  endfunction

  function automatic int m_find(input logic [31:0] va);
    for (int i = 0; i < N; i++)
      if (mv[i] && ((va >> mlg[i]) == (mbase[i] >> mlg[i]))) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    int best = 0;
    for (int i = 0; i < N; i++) if (!mv[i]) return i;
    for (int i = 1; i < N; i++) if (mst[i] < mst[best]) best = i;
    return best;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // issue one operation at a negedge, check the response at the next negedge
  task automatic run_op(input int kind, input logic [31:0] va, input bit upd, input bit wr,
                        input bit probe, input logic [1:0] cpl, input bit fs, input bit wp,
                        input logic [31:0] fr, input int lg, input bit g, input bit u,
                        input bit w, input bit c, input string tag);
    int h;
    bit e_hit = 0, e_nc = 0, e_f = 0, e_fw = 0;
    logic [2:0] e_slot = 0;
    logic [31:0] e_pa = 0, qva;
    logic [63:0] act, exp;
    req_valid = 1; req_op = 3'(kind); req_va = va; req_upd_lru = upd; req_write = wr;
    req_probe = probe; req_cpl = cpl; req_force_sup = fs; wp_en = wp; ins_frame = fr;
    ins_log = 6'(lg); ins_glob = g; ins_user = u; ins_wr = w; ins_nc = c;
    qva = (kind == 1) ? (va & ~low_mask(lg)) : va;
    h = m_find(qva);
    case (kind)
      0: if (h >= 0) begin
           bit usr_mode, badw;
           e_hit = 1; e_slot = 3'(h);
           e_pa = mfr[h] | (va & low_mask(mlg[h]));
           e_nc = mc[h];
           usr_mode = (cpl == 2'd3) && !fs;
           badw = !mw[h] && (usr_mode || wp);
           if (usr_mode && !mu[h]) begin e_f = 1; e_fw = wr; end
           else if (wr && badw)    begin e_f = 1; e_fw = 1; end
           else if (probe && badw) begin e_f = 1; e_fw = 1; end
           if (upd) begin mst[h] = mseq; mseq++; end
         end
      1: if (h >= 0) begin
           e_hit = 1; e_slot = 3'(h);
         end else begin
           int v = m_victim();
           e_slot = 3'(v);
           mv[v] = 1; mbase[v] = qva; mfr[v] = fr; mlg[v] = lg;
           mg[v] = g; mu[v] = u; mw[v] = w; mc[v] = c;
           mst[v] = mseq; mseq++;
         end
      2: for (int i = 0; i < N; i++) mv[i] = 0;
      3: for (int i = 0; i < N; i++) if (!mg[i]) mv[i] = 0;
      default: if (h >= 0) begin
           e_hit = 1; e_slot = 3'(h); mv[h] = 0;
         end
    endcase
    @(negedge clk);
    req_valid = 0;
    act = {25'd0, rsp_valid, rsp_hit, rsp_slot, rsp_pa, rsp_nc, rsp_fault, rsp_fault_wr};
    exp = {25'd0, 1'b1, e_hit, e_slot, e_pa, e_nc, e_f, e_fw};
    chk(act === exp, tag, act, exp);
  endtask

  task automatic lk(input logic [31:0] va, input bit upd, input bit wr, input bit probe,
                    input logic [1:0] cpl, input bit fs, input bit wp, input string tag);
    run_op(0, va, upd, wr, probe, cpl, fs, wp, 32'h0, 12, 0, 0, 0, 0, tag);
  endtask

  task automatic ins(input logic [31:0] va, input logic [31:0] fr, input int lg,
                     input bit g, input bit u, input bit w, input bit c, input string tag);
    run_op(1, va, 0, 0, 0, 2'd0, 0, 0, fr, lg, g, u, w, c, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    lk(32'h0000_5000, 0, 0, 0, 2'd0, 0, 0, "R1 first lookup misses");

    // R5 fill slots in order; page 0 global, 2 uncacheable, 3 read-only, 4 supervisor-only
    for (int p = 0; p < N; p++)
      ins((32'(p) << 12) | 32'h123, 32'h8000_0000 + (32'(p) << 12), 12,
          p == 0, p != 4, p != 3, p == 2, "R5 fill free slot");
    ins(32'h0000_3FFF, 32'h0, 12, 0, 1, 1, 0, "R4 duplicate insert reuses slot");
    lk(32'h0000_5ABC, 0, 0, 0, 2'd0, 0, 0, "R3 translate offset");
    lk(32'h0000_2010, 0, 0, 0, 2'd0, 0, 0, "R3 uncacheable passes");

    // R6 recency: page0 refreshed, page1 looked up without refresh -> slot 1 evicted
    lk(32'h0000_0004, 1, 0, 0, 2'd0, 0, 0, "R6 lookup with update");
    lk(32'h0000_1004, 0, 0, 0, 2'd0, 0, 0, "R6 lookup without update");
    ins(32'h0000_9000, 32'hA000_0000, 12, 0, 1, 1, 0, "R6 evict oldest stamp");
    lk(32'h0000_1004, 0, 0, 0, 2'd0, 0, 0, "R6 evicted page misses");

    // permissions on read-only page 3 and supervisor page 4
    lk(32'h0000_3008, 0, 1, 0, 2'd0, 0, 0, "R11 supervisor write without wp");
    lk(32'h0000_3008, 0, 1, 0, 2'd0, 0, 1, "R11 supervisor write with wp");
    lk(32'h0000_3008, 0, 1, 0, 2'd3, 0, 0, "R11 user write read-only");
    lk(32'h0000_3008, 0, 0, 1, 2'd3, 0, 0, "R12 store probe flagged write");
    lk(32'h0000_5008, 0, 0, 1, 2'd3, 0, 1, "R12 probe writable no fault");
    lk(32'h0000_4008, 0, 0, 0, 2'd3, 0, 0, "R10 user read supervisor page");
    lk(32'h0000_4008, 0, 1, 0, 2'd3, 0, 0, "R10 user write supervisor page");
    lk(32'h0000_4008, 0, 0, 0, 2'd3, 1, 0, "R10 forced supervisor");

    // R9 single page invalidate
    run_op(4, 32'h0000_5777, 0, 0, 0, 2'd0, 0, 0, 32'h0, 12, 0, 0, 0, 0, "R9 invalidate present");
    lk(32'h0000_5000, 0, 0, 0, 2'd0, 0, 0, "R9 invalidated page misses");
    run_op(4, 32'h0000_5777, 0, 0, 0, 2'd0, 0, 0, 32'h0, 12, 0, 0, 0, 0, "R9 invalidate absent");

    // R3 large page into the freed slot
    ins(32'h0004_1234, 32'h9000_0000, 16, 0, 1, 1, 0, "R5 large page fill");
    lk(32'h0004_ABCD, 0, 0, 0, 2'd0, 0, 0, "R3 large page offset");

    // R2 idle cycle
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R2 idle gives no response", 64'(rsp_valid), 64'd0);

    // R8 and R7 flushes
    run_op(3, 0, 0, 0, 0, 2'd0, 0, 0, 32'h0, 12, 0, 0, 0, 0, "R8 flush non-global");
    lk(32'h0000_0040, 0, 0, 0, 2'd0, 0, 0, "R8 global survives");
    lk(32'h0000_2040, 0, 0, 0, 2'd0, 0, 0, "R8 non-global gone");
    run_op(2, 0, 0, 0, 0, 2'd0, 0, 0, 32'h0, 12, 0, 0, 0, 0, "R7 flush all");
    lk(32'h0000_0040, 0, 0, 0, 2'd0, 0, 0, "R7 global gone after flush all");

    // random mix
    for (int n = 0; n < 800; n++) begin
      int r = int'($urandom % 100);
      logic [31:0] va = ((32'($urandom % 20)) << 12) | (32'($urandom) & 32'hFFF);
      int lg = (($urandom % 5) == 0) ? 14 : 12;
      logic [31:0] fr = 32'($urandom) & 32'hFFFF_C000;
      if (r < 45)
        run_op(0, va, 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
               1'($urandom), 32'h0, 12, 0, 0, 0, 0, "R3/R10/R11/R12 random lookup");
      else if (r < 80)
        run_op(1, va, 0, 0, 0, 2'd0, 0, 0, fr, lg, 1'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom), "R4/R5/R6 random insert");
      else if (r < 84)
        run_op(2, va, 0, 0, 0, 2'd0, 0, 0, 32'h0, 12, 0, 0, 0, 0, "R7 random flush");
      else if (r < 89)
        run_op(3, va, 0, 0, 0, 2'd0, 0, 0, 32'h0, 12, 0, 0, 0, 0, "R8 random local flush");
      else
        run_op(4, va, 0, 0, 0, 2'd0, 0, 0, 32'h0, 12, 0, 0, 0, 0, "R9 random invalidate");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule